// File: doc/BRIEF.md
# Radix-complement to sign-magnitude converter

This block turns an n-digit radix-r number held in radix-complement form into the n-digit sign-magnitude number with the same value. Each digit sits in an unsigned field just wide enough for r-1. The radix and the digit count are parameters. A negative input carries r-1 in its top digit, and a non-negative input carries 0 there.

The magnitude is built without an increment carry chain. A prefix OR over the lower digits tells each position whether any digit below it is nonzero. With that tag and the sign, every output digit is picked at the same time: the digit unchanged, its negation modulo r, or its (r-1)-complement. The single negative value that has no sign-magnitude form, -r^(n-1), raises an overflow flag and drops the valid output.

Optional input and output register stages sit around the combinational core. Each is chosen by its own parameter, so the block can sit in a pipeline or be used as pure logic.

Top module: `rcsm_convert`

## Requirements
- R1: When the top digit is 0, sm_out equals rc_in, ovf is 0 and valid is 1.
- R2: When the top digit is r-1 and some lower digit is nonzero, the top digit of sm_out is r-1. The lower n-1 digits of sm_out are then the base-r digits of the magnitude r^n - V, where V is rc_in read as an unsigned base-r number. ovf is 0 and valid is 1.
- R3: For a negative input, each lower position whose digits below it are all zero outputs (r - x) mod r. A zero digit there stays zero, and the lowest nonzero digit x becomes r - x.
- R4: For a negative input, each lower position that has a nonzero digit somewhere below it outputs r-1-x.
- R5: When the top digit is r-1 and all lower digits are 0, ovf is 1, valid is 0 and every bit of sm_out is 0.
- R6: With r=2 and n=5, the input 10011 gives the output 11101.
- R7: With both register stages enabled (the default), sm_out, ovf and valid are all 0 while rst_n is low. A new input reaches the outputs after exactly two rising clock edges, and the outputs keep their old value after the first edge.
- Encoding: digit i sits at bits [i*W +: W], where W = ceil(log2 r) with a minimum of 1. Digit n-1 is the sign digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stages |
| rst_n | input | 1 | Asynchronous active-low reset of the register stages |
| rc_in | input | NDIG*W | Radix-complement input digits |
| sm_out | output | NDIG*W | Sign-magnitude output digits |
| ovf | output | 1 | Input is -r^(n-1), which has no sign-magnitude form |
| valid | output | 1 | sm_out holds a representable result |

## Verification
A wrong tag shows at the ports in the same conversion, two edges after the input is applied. A tag stuck low moves the lowest-nonzero rule upward, so digits that should read r-1-x read (r-x) mod r instead. A tag stuck high does the reverse, and the magnitude then misses by one. A bad sign or overflow decode changes ovf and valid for that input at once. For this reason the bench walks every legal input of a small radix-3 instance and a set of binary patterns that put the lowest nonzero digit at each position.

// File: rtl/rcsm_pkg.sv
package rcsm_pkg;

   // Bits needed to hold one digit of value 0 .. r-1.
   function automatic int digit_bits(input int r);
      return (r <= 2) ? 1 : $clog2(r);
   endfunction

endpackage

// File: rtl/rcsm_stage.sv
// Optional register stage: a plain wire when EN is 0.
module rcsm_stage #(
   parameter int W  = 8,
   parameter bit EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (EN) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_wire
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/rcsm_tag_chain.sv
// Per-position "some lower digit is nonzero" tags, built as a prefix OR.
module rcsm_tag_chain #(
   parameter int NDIG = 4,
   parameter int DW   = 4
) (
   input  logic [NDIG*DW-1:0] x,
   output logic [NDIG-1:0]    below,   // below[i]: some digit j < i is nonzero
   output logic               neg,     // top digit nonzero
   output logic               any_low  // some digit below the top is nonzero
);
   logic [NDIG-1:0] nz;

   always_comb begin
      for (int i = 0; i < NDIG; i++) nz[i] = |x[i*DW +: DW];
      below[0] = 1'b0;
      for (int i = 1; i < NDIG; i++) below[i] = below[i-1] | nz[i-1];
   end

   assign neg     = nz[NDIG-1];
   assign any_low = below[NDIG-1];
endmodule

// File: rtl/rcsm_digit_sel.sv
// Chooses one magnitude digit from the sign and the lower-position tag.
module rcsm_digit_sel #(
   parameter int RADIX = 10,
   parameter int DW    = 4
) (
   input  logic [DW-1:0] x,
   input  logic          below,
   input  logic          neg,
   output logic [DW-1:0] y
);
   localparam logic [DW-1:0] RM1 = DW'(RADIX - 1);

   always_comb begin
      if (!neg)         y = x;                   // non-negative: pass through
      else if (below)   y = RM1 - x;             // above lowest nonzero
      else if (x == '0) y = '0;                  // (-0) mod r
      else              y = RM1 - x + DW'(1);    // r - x
   end
endmodule

// File: rtl/rcsm_convert.sv
module rcsm_convert #(
   parameter  int RADIX   = 10,
   parameter  int NDIG    = 4,
   parameter  bit IN_REG  = 1'b1,
   parameter  bit OUT_REG = 1'b1,
   localparam int DW      = rcsm_pkg::digit_bits(RADIX),
   localparam int VW      = NDIG * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] rc_in,
   output logic [VW-1:0] sm_out,
   output logic          ovf,
   output logic          valid
);
   localparam logic [DW-1:0] RM1 = DW'(RADIX - 1);

   generate
      if (RADIX < 2) begin : g_bad_radix
         $error("rcsm_convert: RADIX must be at least 2");
      end
      if (NDIG < 2) begin : g_bad_ndig
         $error("rcsm_convert: NDIG must be at least 2");
      end
   endgenerate

   logic [VW-1:0]   x_q;
   logic [NDIG-1:0] below;
   logic            neg, any_low;
   logic [VW-1:0]   y_core;
   logic [VW-1:0]   y_fin;
   logic            ovf_c;

   rcsm_stage #(.W(VW), .EN(IN_REG)) u_in_stage (
      .clk(clk), .rst_n(rst_n), .d(rc_in), .q(x_q)
   );

   rcsm_tag_chain #(.NDIG(NDIG), .DW(DW)) u_tags (
      .x(x_q), .below(below), .neg(neg), .any_low(any_low)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NDIG-1; gi++) begin : g_dig
         rcsm_digit_sel #(.RADIX(RADIX), .DW(DW)) u_sel (
            .x(x_q[gi*DW +: DW]), .below(below[gi]), .neg(neg),
            .y(y_core[gi*DW +: DW])
         );

         // R3: lowest nonzero digit of a negative value becomes r - x
         a_r3_lowest_negated: assert property (@(posedge clk) disable iff (!rst_n)
            (neg && !below[gi] && x_q[gi*DW +: DW] != '0) |->
            (({1'b0, y_core[gi*DW +: DW]} + {1'b0, x_q[gi*DW +: DW]}) == (DW+1)'(RADIX)));

         // R4: digits above the lowest nonzero are (r-1)-complemented
         a_r4_upper_complement: assert property (@(posedge clk) disable iff (!rst_n)
            (neg && below[gi]) |->
            ((y_core[gi*DW +: DW] + x_q[gi*DW +: DW]) == RM1));
      end
   endgenerate

   assign y_core[VW-1 -: DW] = x_q[VW-1 -: DW];
   assign ovf_c = neg & ~any_low;
   assign y_fin = ovf_c ? '0 : y_core;

   rcsm_stage #(.W(VW+2), .EN(OUT_REG)) u_out_stage (
      .clk(clk), .rst_n(rst_n),
      .d({ovf_c, ~ovf_c, y_fin}),
      .q({ovf, valid, sm_out})
   );

   // R1: a non-negative value crosses the core unchanged
   a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (x_q[VW-1 -: DW] == '0) |-> (y_core == x_q));

   // R5: an overflow result carries no digits
   a_r5_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (sm_out == '0));

   // R5: overflow and valid never both high
   a_r5_ovf_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> !ovf);
endmodule

// File: tb/test_rcsm_convert.sv
module test_rcsm_convert;
   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic       rst_n;
   logic [5:0] t_in, t_out;
   logic       t_ovf, t_val;
   logic [4:0] b_in, b_out;
   logic       b_ovf, b_val;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // radix 3, three digits, two bits per digit
   rcsm_convert #(.RADIX(3), .NDIG(3)) i_rcsm_convert (
      .clk(clk), .rst_n(rst_n), .rc_in(t_in),
      .sm_out(t_out), .ovf(t_ovf), .valid(t_val)
   );

   // binary, five digits
   rcsm_convert #(.RADIX(2), .NDIG(5)) i_rcsm_convert_bin (
      .clk(clk), .rst_n(rst_n), .rc_in(b_in),
      .sm_out(b_out), .ovf(b_ovf), .valid(b_val)
   );

   typedef struct packed {
      logic [4:0] vin;
      logic [4:0] vexp;
      logic       vovf;
      logic [3:0] rq;
   } vec_t;

   // Binary vectors: R1 pass-through, R3 low digits, R4 upper digits,
   // R5 overflow, R6 the worked conversion.
   localparam vec_t TBL [10] = '{
      '{5'b00000, 5'b00000, 1'b0, 4'd1},
      '{5'b00111, 5'b00111, 1'b0, 4'd1},
      '{5'b01111, 5'b01111, 1'b0, 4'd1},
      '{5'b10011, 5'b11101, 1'b0, 4'd6},
      '{5'b11111, 5'b10001, 1'b0, 4'd4},
      '{5'b11000, 5'b11000, 1'b0, 4'd3},
      '{5'b10001, 5'b11111, 1'b0, 4'd4},
      '{5'b11110, 5'b10010, 1'b0, 4'd3},
      '{5'b10100, 5'b11100, 1'b0, 4'd3},
      '{5'b10000, 5'b00000, 1'b1, 4'd5}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (2) @(posedge clk);
      #5;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      t_in  = 6'b100000;
      b_in  = 5'b11111;
      repeat (3) @(posedge clk);
      #5;
      // R7: reset state
      check("R7 reset sm_out", 32'(b_out), 32'd0);
      check("R7 reset valid", 32'(b_val), 32'd0);
      check("R7 reset ovf", 32'(b_ovf), 32'd0);
      check("R7 reset sm_out r3", 32'(t_out), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // binary table
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         b_in = TBL[k].vin;
         settle();
         check($sformatf("R%0d sm_out in=%b", TBL[k].rq, TBL[k].vin), 32'(b_out), 32'(TBL[k].vexp));
         check($sformatf("R%0d ovf in=%b", TBL[k].rq, TBL[k].vin), 32'(b_ovf), 32'(TBL[k].vovf));
         check($sformatf("R%0d valid in=%b", TBL[k].rq, TBL[k].vin), 32'(b_val), 32'(!TBL[k].vovf));
      end

      // exhaustive radix-3: top digit 0 (R1) or 2 (R2/R5)
      for (int top = 0; top <= 2; top += 2) begin
         for (int low = 0; low < 9; low++) begin
            int d1, d0, mag;
            logic [5:0] exp_sm;
            logic exp_ovf;
            d1 = low / 3;
            d0 = low % 3;
            exp_ovf = 1'b0;
            if (top == 0) begin
               exp_sm = {2'd0, 2'(d1), 2'(d0)};
            end else begin
               mag = 9 - low;
               if (mag == 9) begin
                  exp_ovf = 1'b1;
                  exp_sm = '0;
               end else begin
                  exp_sm = {2'd2, 2'(mag / 3), 2'(mag % 3)};
               end
            end
            @(negedge clk);
            t_in = {2'(top), 2'(d1), 2'(d0)};
            settle();
            if (top == 0)      check($sformatf("R1 r3 sm_out low=%0d", low), 32'(t_out), 32'(exp_sm));
            else if (exp_ovf)  check("R5 r3 sm_out", 32'(t_out), 32'(exp_sm));
            else               check($sformatf("R2 r3 sm_out low=%0d", low), 32'(t_out), 32'(exp_sm));
            check($sformatf("R2 r3 ovf top=%0d low=%0d", top, low), 32'(t_ovf), 32'(exp_ovf));
            check($sformatf("R2 r3 valid top=%0d low=%0d", top, low), 32'(t_val), 32'(!exp_ovf));
         end
      end

      // R7: two-edge latency, old value held after the first edge
      @(negedge clk);
      b_in = 5'b00111;
      settle();
      @(negedge clk);
      b_in = 5'b11111;
      @(posedge clk);
      #5;
      check("R7 hold after one edge", 32'(b_out), 32'h07);
      @(posedge clk);
      #5;
      check("R7 update after two edges", 32'(b_out), 32'h11);

      // R5 then R1 back to back: flag clears on next value
      @(negedge clk);
      b_in = 5'b10000;
      settle();
      check("R5 ovf directed", 32'(b_ovf), 32'd1);
      @(negedge clk);
      b_in = 5'b00000;
      settle();
      check("R1 zero after overflow valid", 32'(b_val), 32'd1);
      check("R1 zero after overflow ovf", 32'(b_ovf), 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule